// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block is a watchdog counter that runs by itself from the moment its reset is released. It is clocked by a 32.768 kHz low-speed clock and cannot be halted by software. When the count reaches the end of the selected period, the block wraps to zero. The first such expiry raises a one-cycle non-maskable interrupt request, which gives software a last chance to recover. If a second expiry follows with no restart in between, the block raises a system reset request. That request stays high until the block itself is reset.

Software keeps the watchdog quiet by restarting it through a small write port. A restart counts only when two particular byte values arrive on two successive write strobes. One of four periods is chosen with a select input. The choice is captured only when a restart is accepted, so a stray change of the select lines cannot shorten a count that is already running. A status output shows that the interrupt stage has fired and that the next expiry will request a reset.

Top module: `twostage_wdt`

## Requirements
- R1: While `rst_n` is low, `nmi_pulse`, `reset_req` and `warn_pending` are 0. Asserting `rst_n` clears `reset_req` at once, without waiting for a clock edge.
- R2: The release of `rst_n` is synchronised through two flops. With no software action, the counter then runs with period code 0, and the first `nmi_pulse` appears exactly 2^BASE_LOG2 + 2 clock edges after the release.
- R3: The first expiry after a restart drives `nmi_pulse` high for exactly one cycle, 2^BASE_LOG2·4^code edges after the accepting edge. `warn_pending` is 1 from that cycle onwards.
- R4: A second expiry with no restart in between raises `reset_req` one period after the interrupt. `reset_req` then stays 1, and later restarts do not clear it. Only `rst_n` clears it.
- R5: Period code c (0 to 3 on `period_sel`) gives a period of 2^(BASE_LOG2 + 2c) clock edges. With the default BASE_LOG2 = 12, these are 4096, 16384, 65536 and 262144 ticks (125 ms, 500 ms, 2 s and 8 s at 32.768 kHz).
- R6: A restart is accepted when a strobe carrying 0xA5 directly follows a strobe carrying 0x5A. Idle cycles between the two strobes are allowed. A strobe with any other value discards the partial key. A repeated 0x5A leaves the key armed. An accepted restart zeroes the count and clears `warn_pending` on the accepting edge.
- R7: A change of `period_sel` has no effect until the next accepted restart, which captures it. After reset the captured code is 0.
- R8: When a restart is accepted on the same edge as an expiry, the restart wins. No interrupt is raised, and the next interrupt comes one full period after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed clock (32.768 kHz) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_sel | input | SEL_W | Period code, captured on an accepted restart |
| clr_we | input | 1 | Restart-key write strobe |
| clr_data | input | KEY_W | Key byte written with the strobe |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request on the first expiry |
| reset_req | output | 1 | Sticky system reset request on the second expiry |
| warn_pending | output | 1 | Interrupt stage fired; the next expiry requests a reset |

## Verification
The two functions that can fall on the same clock edge are the acceptance of a restart and the expiry of the count. The bench places the closing 0xA5 strobe so that it is sampled on exactly the edge where the count wraps. It works out that edge from the cycle in which the earlier restart was accepted. The outcome is judged at the ports: `nmi_pulse` must stay low and `warn_pending` must be clear after that edge, and the next interrupt must arrive one full period later, counted from that edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] KEY_ARM  = 8'h5A;
  localparam logic [KEY_W-1:0] KEY_FIRE = 8'hA5;

  typedef enum logic {
    STG_CLEAR  = 1'b0,
    STG_WARNED = 1'b1
  } wdt_stage_e;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_we,
  input  logic [KEY_W-1:0] clr_data,
  output logic             restart
);
  logic armed_q;
  logic armed_d;
  logic hit;

  always_comb begin
    armed_d = armed_q;
    hit     = 1'b0;
    if (clr_we) begin
      if (armed_q && (clr_data == KEY_FIRE)) begin
        hit     = 1'b1;
        armed_d = 1'b0;
      end else begin
        armed_d = (clr_data == KEY_ARM);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (clr_we) armed_q <= armed_d;
  end

  assign restart = hit;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int BASE_LOG2 = 12,
  parameter int STEP_LOG2 = 2,
  parameter int SEL_W     = 2,
  parameter int CNT_W     = BASE_LOG2 + STEP_LOG2 * ((1 << SEL_W) - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] period_sel,
  output logic             expire,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] last_val
);
  localparam int NCODES = 1 << SEL_W;

  logic [CNT_W-1:0] lim_tab [NCODES];
  logic [SEL_W-1:0] code_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  for (genvar g = 0; g < NCODES; g++) begin : g_lim
    assign lim_tab[g] = {CNT_W{1'b1}} >> (STEP_LOG2 * (NCODES - 1 - g));
  end

  assign last_val = lim_tab[code_q];
  assign expire   = (cnt_q == last_val);

  always_comb begin
    if (restart)     cnt_d = '0;
    else if (expire) cnt_d = '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (restart) code_q <= period_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic restart,
  output logic nmi,
  output logic trip,
  output logic warned
);
  wdt_stage_e stg_q, stg_d;
  logic       nmi_q, nmi_d;
  logic       trip_q, trip_d;

  always_comb begin
    stg_d  = stg_q;
    nmi_d  = 1'b0;
    trip_d = trip_q;
    if (restart) begin
      stg_d = STG_CLEAR;
    end else if (expire) begin
      if (stg_q == STG_CLEAR) begin
        stg_d = STG_WARNED;
        nmi_d = 1'b1;
      end else begin
        trip_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= STG_CLEAR;
      nmi_q  <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      stg_q  <= stg_d;
      nmi_q  <= nmi_d;
      trip_q <= trip_d;
    end
  end

  assign nmi    = nmi_q;
  assign trip   = trip_q;
  assign warned = (stg_q == STG_WARNED);
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int STEP_LOG2 = 2,
  parameter int SEL_W     = 2,
  parameter int SYNC_LEN  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] period_sel,
  input  logic             clr_we,
  input  logic [KEY_W-1:0] clr_data,
  output logic             nmi_pulse,
  output logic             reset_req,
  output logic             warn_pending
);
  localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * ((1 << SEL_W) - 1);

  logic             rst_sync_n;
  logic             restart_hit;
  logic             expire;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] last_val;

  wdt_rst_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  wdt_unlock u_key (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .restart  (restart_hit)
  );

  wdt_counter #(
    .BASE_LOG2 (BASE_LOG2),
    .STEP_LOG2 (STEP_LOG2),
    .SEL_W     (SEL_W),
    .CNT_W     (CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .restart    (restart_hit),
    .period_sel (period_sel),
    .expire     (expire),
    .count      (count),
    .last_val   (last_val)
  );

  wdt_escalate u_esc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .expire  (expire),
    .restart (restart_hit),
    .nmi     (nmi_pulse),
    .trip    (reset_req),
    .warned  (warn_pending)
  );
endmodule

// File: rtl/twostage_wdt_chk.sv
module twostage_wdt_chk #(
  parameter int CNT_W = 18
) (
  input logic             clk,
  input logic             srst_n,
  input logic             nmi,
  input logic             trip,
  input logic             pending,
  input logic             restart,
  input logic             expire,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] last_val
);
  a_r3_nmi_single: assert property (@(posedge clk) disable iff (!srst_n)
    nmi |=> !nmi);

  a_r3_nmi_sets_pending: assert property (@(posedge clk) disable iff (!srst_n)
    nmi |-> pending);

  a_r4_trip_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    trip |=> trip);

  a_r4_trip_after_warn: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(trip) |-> $past(pending));

  a_r6_restart_zeroes: assert property (@(posedge clk) disable iff (!srst_n)
    restart |=> (count == '0) && !pending);

  a_r8_restart_beats_expiry: assert property (@(posedge clk) disable iff (!srst_n)
    (restart && expire) |=> !nmi);

  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!srst_n)
    count <= last_val);

  a_r2_free_running: assert property (@(posedge clk) disable iff (!srst_n)
    (!restart && !expire) |=> count == $past(count) + CNT_W'(1));
endmodule

bind twostage_wdt twostage_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .srst_n   (rst_sync_n),
  .nmi      (nmi_pulse),
  .trip     (reset_req),
  .pending  (warn_pending),
  .restart  (restart_hit),
  .expire   (expire),
  .count    (count),
  .last_val (last_val)
);

// File: tb/twostage_wdt_test.sv
module twostage_wdt_test;
  localparam int BASE = 4;
  localparam int TC0  = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       we = 1'b0;
  logic [7:0] data = 8'h00;
  logic       nmi, rreq, pend;

  // code, expected period in edges (R5 with BASE = 4)
  localparam int VEC [4][2] = '{'{2, 256}, '{0, 16}, '{3, 1024}, '{1, 64}};

  int cyc = 0;
  int r0 = 0;
  int n_chk = 0;
  int n_bad = 0;
  int d;
  bit done = 1'b0;

  twostage_wdt #(.BASE_LOG2(BASE)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_sel   (sel),
    .clr_we       (we),
    .clr_data     (data),
    .nmi_pulse    (nmi),
    .reset_req    (rreq),
    .warn_pending (pend)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic strobe(input logic [7:0] v);
    @(negedge clk);
    we = 1'b1;
    data = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_restart();
    strobe(8'h5A);
    strobe(8'hA5);
    r0 = cyc;
  endtask

  task automatic wait_nmi(input int cap, output int dd);
    while (nmi !== 1'b1 && (cyc - r0) < cap) @(negedge clk);
    dd = cyc - r0;
  endtask

  task automatic wait_rreq(input int cap, output int dd);
    while (rreq !== 1'b1 && (cyc - r0) < cap) @(negedge clk);
    dd = cyc - r0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, got %0d expected 0", cyc);
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 nmi in reset", nmi, 0);
    check("R1 reset_req in reset", rreq, 0);
    check("R1 pending in reset", pend, 0);

    // R2: free running from reset with code 0, two-flop release
    rst_n = 1'b1;
    r0 = cyc;
    wait_nmi(200, d);
    check("R2 first nmi after release", d, TC0 + 2);
    check("R3 pending after first nmi", pend, 1);
    @(negedge clk);
    check("R3 nmi one cycle", nmi, 0);
    wait_rreq(400, d);
    check("R4 reset_req after second expiry", d, 2 * TC0 + 2);
    do_restart();
    check("R4 reset_req survives restart", rreq, 1);
    check("R6 restart clears pending", pend, 0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async clear of reset_req", rreq, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5 / R3 / R6: period table
    for (int i = 0; i < 4; i++) begin
      sel = VEC[i][0][1:0];
      do_restart();
      check("R6 pending cleared by restart", pend, 0);
      wait_nmi(3000, d);
      check("R5 period for code", d, VEC[i][1]);
      check("R3 pending set", pend, 1);
      @(negedge clk);
      check("R3 nmi pulse width", nmi, 0);
    end

    // R7: select change waits for a restart
    sel = 2'd0;
    do_restart();
    sel = 2'd3;
    wait_nmi(3000, d);
    check("R7 old period kept", d, TC0);
    sel = 2'd0;

    // R6: broken key is discarded
    do_restart();
    strobe(8'h5A);
    strobe(8'h33);
    strobe(8'hA5);
    wait_nmi(3000, d);
    check("R6 broken key ignored", d, TC0);

    // R6: idle cycles between key strobes
    do_restart();
    strobe(8'h5A);
    repeat (5) @(negedge clk);
    strobe(8'hA5);
    r0 = cyc;
    wait_nmi(3000, d);
    check("R6 gapped key accepted", d, TC0);

    // R6: repeated arm value keeps key armed
    do_restart();
    strobe(8'h5A);
    strobe(8'h5A);
    strobe(8'hA5);
    r0 = cyc;
    wait_nmi(3000, d);
    check("R6 double arm accepted", d, TC0);

    // R8: restart on the expiry edge
    do_restart();
    while (cyc < r0 + TC0 - 2) @(negedge clk);
    we = 1'b1;
    data = 8'h5A;
    @(negedge clk);
    data = 8'hA5;
    @(negedge clk);
    we = 1'b0;
    check("R8 no nmi on coincident restart", nmi, 0);
    check("R8 pending stays clear", pend, 0);
    r0 = r0 + TC0;
    wait_nmi(3000, d);
    check("R8 next nmi one period later", d, TC0);

    // R4: escalation from a restart
    do_restart();
    wait_nmi(3000, d);
    check("R3 nmi after restart", d, TC0);
    wait_rreq(3000, d);
    check("R4 reset_req one period after nmi", d, 2 * TC0);
    repeat (3) @(negedge clk);
    check("R4 reset_req held", rreq, 1);

    finish_run();
  end
endmodule